// File: doc/BRIEF.md
# SDIO Read-Wait Pause Controller

This controller lets an SD host stop a multi-block read for a while so that commands can go out on the CMD line, and then pick the read up again. It sits between two plain control requests from software (enter read-wait, release read-wait) and the data engine's byte and block counters. The data engine reports each block boundary (end bit and CRC received), the start of a transfer and the end of a transfer. The controller returns a freeze enable that holds those counters and their status.

The card clock is never gated to create the pause. The controller only freezes the host-side counters and, on a 4-bit bus, signals the pause to the card on DAT2. DAT2 is pulled low for the whole pause. On release it is driven high for one cycle and then left floating.

While the transfer is paused, a command-allowed flag tells the command engine when it may start a command. The flag enforces the minimum gap between commands, and the minimum gap after a response. A request that arrives while no multi-block read is running is dropped, and a sticky flag reports that read-wait was not entered. All pins are plain level or single-cycle pulse controls. No data passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `sdio_readwait_ctl`

## Requirements
- R1: After reset, freeze, cmd_ok, dat2_oe and rw_rej are all 0 and dat2_out is 1.
- R2: A rw_req pulse during a transfer that does not coincide with blk_end does not freeze the counters: freeze stays 0 until a blk_end pulse arrives, and rises in the cycle after that pulse.
- R3: A rw_req pulse that coincides with blk_end during a transfer pauses at that same boundary: freeze is 1 in the next cycle.
- R4: freeze stays 1 for the whole pause and for the single release cycle that follows a rw_release pulse. It returns to 0 two cycles after the rw_release pulse, and the transfer then continues.
- R5: With a 4-bit bus, dat2_oe=1 and dat2_out=0 while paused. In the release cycle dat2_oe=1 and dat2_out=1. After that, dat2_oe=0.
- R6: The bus width is taken from wide_bus (1 = 4-bit) in the cycle of xfer_start, and later changes to wide_bus have no effect on that transfer. With a 1-bit bus, dat2_oe is never 1.
- R7: cmd_ok is 1 only while paused (not during the release cycle), with no command outstanding, and only after at least GAP_MIN (8) cycles since the last cmd_issue or rsp_end pulse. A cmd_issue makes a command outstanding until rsp_end.
- R8: A rw_req pulse when no transfer is running is ignored and sets rw_rej to 1. rw_rej is cleared by the next xfer_start or by the next accepted rw_req.
- R9: An xfer_done pulse while waiting for a boundary ends the transfer without pausing and sets rw_rej to 1. This holds even when blk_end arrives in the same cycle.
- R10: rw_release outside a pause is ignored. rw_req and xfer_done during a pause are ignored, and freeze stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Pulse: multi-block read begins |
| xfer_done | input | 1 | Pulse: multi-block read ends |
| wide_bus | input | 1 | 1 = 4-bit bus, 0 = 1-bit bus, sampled at xfer_start |
| blk_end | input | 1 | Pulse: end bit and CRC of a block received |
| rw_req | input | 1 | Pulse: software asks for read-wait |
| rw_release | input | 1 | Pulse: software ends read-wait |
| cmd_issue | input | 1 | Pulse: command engine starts a command |
| rsp_end | input | 1 | Pulse: command response finished |
| freeze | output | 1 | Hold transfer counters and status |
| cmd_ok | output | 1 | A command may be started now |
| dat2_out | output | 1 | Value driven on DAT2 |
| dat2_oe | output | 1 | DAT2 output enable |
| rw_rej | output | 1 | Last read-wait request was not entered |

## Verification
Two events can land in the same cycle: a read-wait request and the block boundary it waits for. The bench raises rw_req and blk_end on the same edge and expects freeze one cycle later. A second coincidence is the transfer ending while a boundary is being awaited. The bench raises xfer_done together with blk_end and expects the end of transfer to win: freeze stays low and rw_rej is set. A request during a pause is also provoked, and is judged by freeze staying high with rw_rej unchanged.

// File: rtl/rwp_pkg.sv
package rwp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_XFER  = 3'd1,
    ST_WAITB = 3'd2,
    ST_PAUSE = 3'd3,
    ST_RELS  = 3'd4
  } rw_state_t;
endpackage

// File: rtl/rw_seq.sv
module rw_seq
  import rwp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      xfer_start,
  input  logic      xfer_done,
  input  logic      wide_bus,
  input  logic      blk_end,
  input  logic      rw_req,
  input  logic      rw_release,
  output rw_state_t state_o,
  output logic      mode_wide_o,
  output logic      rej_o,
  output logic      freeze_o
);
  rw_state_t st, st_nx;
  logic rej_nx;

  always_comb begin
    st_nx  = st;
    rej_nx = rej_o;
    unique case (st)
      ST_IDLE: begin
        if (xfer_start) begin
          st_nx  = ST_XFER;
          rej_nx = 1'b0;
        end else if (rw_req) begin
          rej_nx = 1'b1;
        end
      end
      ST_XFER: begin
        if (xfer_done) begin
          st_nx = ST_IDLE;
          if (rw_req) rej_nx = 1'b1;
        end else if (rw_req) begin
          rej_nx = 1'b0;
          st_nx  = blk_end ? ST_PAUSE : ST_WAITB;
        end
      end
      ST_WAITB: begin
        if (xfer_done) begin
          st_nx  = ST_IDLE;
          rej_nx = 1'b1;
        end else if (blk_end) begin
          st_nx = ST_PAUSE;
        end
      end
      ST_PAUSE: begin
        if (rw_release) st_nx = ST_RELS;
      end
      ST_RELS:  st_nx = ST_XFER;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      rej_o       <= 1'b0;
      mode_wide_o <= 1'b0;
    end else begin
      st    <= st_nx;
      rej_o <= rej_nx;
      if (st == ST_IDLE && xfer_start) mode_wide_o <= wide_bus;
    end
  end

  assign state_o  = st;
  assign freeze_o = (st == ST_PAUSE) || (st == ST_RELS);

  // R2
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAITB && !blk_end && !xfer_done) |=> (st == ST_WAITB));
  // R3
  same_edge_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XFER && rw_req && blk_end && !xfer_done) |=> (st == ST_PAUSE));
  // R4
  release_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RELS) |=> (st == ST_XFER));
  // R9
  done_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAITB && xfer_done) |=> (st == ST_IDLE && rej_o));
  // R10
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PAUSE && !rw_release) |=> (st == ST_PAUSE));
endmodule

// File: rtl/rw_cmd_gap.sv
module rw_cmd_gap #(
  parameter int GAP_MIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic paused,
  input  logic cmd_issue,
  input  logic rsp_end,
  output logic cmd_ok
);
  localparam int CW = $clog2(GAP_MIN + 1);
  localparam logic [CW-1:0] GAP_TOP = CW'(GAP_MIN);

  logic [CW-1:0] gap_cnt;
  logic          busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= GAP_TOP;
      busy    <= 1'b0;
    end else begin
      if (cmd_issue || rsp_end) gap_cnt <= '0;
      else if (gap_cnt != GAP_TOP) gap_cnt <= gap_cnt + 1'b1;
      if (cmd_issue) busy <= 1'b1;
      else if (rsp_end) busy <= 1'b0;
    end
  end

  assign cmd_ok = paused && !busy && (gap_cnt == GAP_TOP);

  // R7
  issue_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |=> !cmd_ok);
  // R7
  rsp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_end |=> !cmd_ok);
endmodule

// File: rtl/rw_dat2_drv.sv
module rw_dat2_drv
  import rwp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rw_state_t st,
  input  logic      mode_wide,
  output logic      dat2_out,
  output logic      dat2_oe
);
  always_comb begin
    dat2_oe  = 1'b0;
    dat2_out = 1'b1;
    if (mode_wide) begin
      if (st == ST_PAUSE) begin
        dat2_oe  = 1'b1;
        dat2_out = 1'b0;
      end else if (st == ST_RELS) begin
        dat2_oe  = 1'b1;
        dat2_out = 1'b1;
      end
    end
  end

  // R5
  release_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat2_oe && dat2_out) |=> !dat2_oe);
  // R6
  narrow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wide |-> !dat2_oe);
endmodule

// File: rtl/sdio_readwait_ctl.sv
module sdio_readwait_ctl
  import rwp_pkg::*;
#(
  parameter int GAP_MIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_start,
  input  logic xfer_done,
  input  logic wide_bus,
  input  logic blk_end,
  input  logic rw_req,
  input  logic rw_release,
  input  logic cmd_issue,
  input  logic rsp_end,
  output logic freeze,
  output logic cmd_ok,
  output logic dat2_out,
  output logic dat2_oe,
  output logic rw_rej
);
  rw_state_t st;
  logic      mode_wide;

  rw_seq seq_i (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_done(xfer_done),
    .wide_bus(wide_bus), .blk_end(blk_end), .rw_req(rw_req),
    .rw_release(rw_release), .state_o(st), .mode_wide_o(mode_wide),
    .rej_o(rw_rej), .freeze_o(freeze)
  );

  rw_cmd_gap #(.GAP_MIN(GAP_MIN)) gap_i (
    .clk(clk), .rst_n(rst_n), .paused(st == ST_PAUSE),
    .cmd_issue(cmd_issue), .rsp_end(rsp_end), .cmd_ok(cmd_ok)
  );

  rw_dat2_drv drv_i (
    .clk(clk), .rst_n(rst_n), .st(st), .mode_wide(mode_wide),
    .dat2_out(dat2_out), .dat2_oe(dat2_oe)
  );

  // R5
  low_means_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat2_oe && !dat2_out) |-> freeze);
  // R7
  cmd_needs_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |-> freeze);
endmodule

// File: tb/sdio_readwait_ctl_tb_top.sv
module sdio_readwait_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_start = 0, xfer_done = 0, wide_bus = 0, blk_end = 0;
  logic rw_req = 0, rw_release = 0, cmd_issue = 0, rsp_end = 0;
  logic freeze, cmd_ok, dat2_out, dat2_oe, rw_rej;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sdio_readwait_ctl #(.GAP_MIN(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_done(xfer_done),
    .wide_bus(wide_bus), .blk_end(blk_end), .rw_req(rw_req),
    .rw_release(rw_release), .cmd_issue(cmd_issue), .rsp_end(rsp_end),
    .freeze(freeze), .cmd_ok(cmd_ok), .dat2_out(dat2_out),
    .dat2_oe(dat2_oe), .rw_rej(rw_rej)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // one clock: inputs set before are sampled, then cleared; outputs settle by the next negedge
  task automatic step();
    @(negedge clk);
    xfer_start = 0; xfer_done = 0; blk_end = 0; rw_req = 0;
    rw_release = 0; cmd_issue = 0; rsp_end = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    chk("R1", "freeze", freeze, 1'b0);
    chk("R1", "cmd_ok", cmd_ok, 1'b0);
    chk("R1", "dat2_oe", dat2_oe, 1'b0);
    chk("R1", "dat2_out", dat2_out, 1'b1);
    chk("R1", "rw_rej", rw_rej, 1'b0);
  endtask

  task automatic t_idle_reject();
    rw_req = 1; step();
    chk("R8", "rej after idle req", rw_rej, 1'b1);
    chk("R8", "no freeze in idle", freeze, 1'b0);
    wide_bus = 1; xfer_start = 1; step();
    chk("R8", "rej cleared by start", rw_rej, 1'b0);
  endtask

  task automatic t_wide_pause();
    rw_req = 1; step();
    chk("R2", "freeze before boundary", freeze, 1'b0);
    repeat (3) step();
    chk("R2", "freeze still low", freeze, 1'b0);
    chk("R7", "cmd_ok while streaming", cmd_ok, 1'b0);
    blk_end = 1; step();
    chk("R2", "freeze after boundary", freeze, 1'b1);
    chk("R5", "dat2_oe paused", dat2_oe, 1'b1);
    chk("R5", "dat2_out paused", dat2_out, 1'b0);
    chk("R7", "cmd_ok paused", cmd_ok, 1'b1);
    cmd_issue = 1; step();
    chk("R7", "cmd_ok after issue", cmd_ok, 1'b0);
    repeat (10) step();
    chk("R7", "cmd_ok while outstanding", cmd_ok, 1'b0);
    rsp_end = 1; step();
    repeat (7) step();
    chk("R7", "cmd_ok 7 after rsp", cmd_ok, 1'b0);
    chk("R4", "freeze held", freeze, 1'b1);
    step();
    chk("R7", "cmd_ok 8 after rsp", cmd_ok, 1'b1);
    rw_release = 1; step();
    chk("R4", "freeze in release", freeze, 1'b1);
    chk("R5", "dat2_oe release", dat2_oe, 1'b1);
    chk("R5", "dat2_out release", dat2_out, 1'b1);
    chk("R7", "cmd_ok in release", cmd_ok, 1'b0);
    step();
    chk("R4", "freeze resumed", freeze, 1'b0);
    chk("R5", "dat2 floated", dat2_oe, 1'b0);
  endtask

  task automatic t_same_edge();
    rw_req = 1; blk_end = 1; step();
    chk("R3", "freeze same-edge", freeze, 1'b1);
    chk("R3", "dat2 low", dat2_out, 1'b0);
    rw_release = 1; step(); step();
    chk("R4", "freeze off", freeze, 1'b0);
  endtask

  task automatic t_ignored();
    rw_release = 1; step();
    chk("R10", "release while streaming", freeze, 1'b0);
    chk("R10", "dat2 stays off", dat2_oe, 1'b0);
    rw_req = 1; blk_end = 1; step();
    chk("R10", "still streaming, pause ok", freeze, 1'b1);
    rw_req = 1; step();
    chk("R10", "req in pause", freeze, 1'b1);
    chk("R10", "rej unchanged", rw_rej, 1'b0);
    xfer_done = 1; step();
    chk("R10", "done in pause", freeze, 1'b1);
    rw_release = 1; step(); step();
    chk("R10", "resumed", freeze, 1'b0);
    xfer_done = 1; step();
    rw_req = 1; step();
    chk("R8", "idle after done", rw_rej, 1'b1);
  endtask

  task automatic t_narrow();
    wide_bus = 0; xfer_start = 1; step();
    wide_bus = 1;
    rw_req = 1; blk_end = 1; step();
    chk("R6", "freeze narrow", freeze, 1'b1);
    chk("R6", "dat2_oe narrow", dat2_oe, 1'b0);
    rw_release = 1; step();
    chk("R6", "dat2_oe narrow release", dat2_oe, 1'b0);
    step();
    xfer_done = 1; step();
  endtask

  task automatic t_done_in_wait();
    wide_bus = 1; xfer_start = 1; step();
    rw_req = 1; step();
    xfer_done = 1; blk_end = 1; step();
    chk("R9", "no freeze", freeze, 1'b0);
    chk("R9", "rej set", rw_rej, 1'b1);
    chk("R9", "dat2 off", dat2_oe, 1'b0);
    rw_req = 1; blk_end = 1; step();
    chk("R9", "idle: no freeze", freeze, 1'b0);
  endtask

  initial begin
    t_reset();
    t_idle_reject();
    t_wide_pause();
    t_same_edge();
    t_ignored();
    t_narrow();
    t_done_in_wait();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule